// File: doc/BRIEF.md
# Subroutine Call/Return Stack with Flag Save

This block handles subroutine linkage for a small processor core. A return frame goes into a shared stack memory through one of two stack pointers. A call stores the return address and the carry and zero flags in one frame word at the selected pointer, advances that pointer, and redirects the program counter to the call target. A return steps the same pointer back, reads the frame, and redirects to the saved address. On a return, each flag is taken from the frame only if its restore enable is set. Otherwise the flag keeps the value the core supplied with the request.

Each instruction picks its stack pointer, so the two pointers can hold two independent stacks. Pointer A resets to entry 0 and pointer B resets to a parameterised entry, by default the middle of the memory. A delayed form of call or return lets two more issued instructions complete before the redirect strobe fires. The core reports each issued instruction on a single-cycle `issue` input.

Top module: `callret_stack`

## Requirements
- R1: A call stores the frame {C in bit 31, Z in bit 30, zeros, return address in bits [AW-1:0]} at the entry addressed by the selected pointer, then increments that pointer by one.
- R2: A non-delayed call raises `redirect` for one cycle, starting the cycle after the request. `new_pc` equals the target, `new_c`/`new_z` equal the request's flags, and the stored return address is `cur_pc`+1.
- R3: A return decrements the selected pointer, reads the entry at the decremented value, and redirects to that entry's address bits. A non-delayed return redirects the cycle after the request.
- R4: On a return, `new_c` is frame bit 31 when `rest_c` is 1 and `cur_c` otherwise. `new_z` is frame bit 30 when `rest_z` is 1 and `cur_z` otherwise.
- R5: A delayed call or return (`delayed`=1) stores `cur_pc`+3 as the return address on a call. It raises `redirect` for one cycle, starting the cycle after the second `issue` pulse that follows the request cycle. Before that, `redirect` stays low.
- R6: `use_b`=0 selects pointer A and `use_b`=1 selects pointer B. The pointer not selected does not change.
- R7: While a delayed redirect is pending, call and return requests are ignored, and both pointers and the memory stay unchanged.
- R8: Pointers wrap modulo 2^PW, so a return with pointer A at 0 leaves it at 2^PW-1.
- R9: After reset, `redirect`=0, `ptr_a`=0 and `ptr_b`=B_INIT.
- R10: When `call_req` and `ret_req` are both asserted, the call is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Call request |
| ret_req | input | 1 | Return request |
| use_b | input | 1 | Pointer select: 0 = A, 1 = B |
| delayed | input | 1 | Delayed form: redirect after two issued instructions |
| issue | input | 1 | One pulse per issued instruction |
| target | input | AW | Call target address |
| cur_pc | input | AW | Address of the call/return instruction |
| cur_c | input | 1 | Current carry flag |
| cur_z | input | 1 | Current zero flag |
| rest_c | input | 1 | Restore carry from frame on return |
| rest_z | input | 1 | Restore zero from frame on return |
| new_pc | output | AW | Redirect address, valid with `redirect` |
| new_c | output | 1 | Carry after the call/return, valid with `redirect` |
| new_z | output | 1 | Zero after the call/return, valid with `redirect` |
| redirect | output | 1 | One-cycle PC redirect strobe |
| ptr_a | output | PW | Stack pointer A |
| ptr_b | output | PW | Stack pointer B |

## Verification
The hardest case to reach is a request that arrives while a delayed redirect is still waiting for its second issued instruction. The stimulus opens delayed windows with randomly sized gaps between the two `issue` pulses. Inside a gap it injects a stray call or return, then checks that neither pointer moved and that a later return still recovers the frame pushed before the window. A directed return on an empty pointer A forces the wrap to the top entry. A push and pop then go through that wrapped slot.

// File: rtl/callret_stack.sv
module callret_stack #(
  parameter int AW     = 12,
  parameter int PW     = 5,
  parameter int B_INIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          use_b,
  input  logic          delayed,
  input  logic          issue,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] cur_pc,
  input  logic          cur_c,
  input  logic          cur_z,
  input  logic          rest_c,
  input  logic          rest_z,
  output logic [AW-1:0] new_pc,
  output logic          new_c,
  output logic          new_z,
  output logic          redirect,
  output logic [PW-1:0] ptr_a,
  output logic [PW-1:0] ptr_b
);
  localparam int DEPTH = 1 << PW;
  localparam int FW    = 32;
  localparam int PADW  = FW - 2 - AW;

  logic [FW-1:0] mem [DEPTH];
  logic          pend;
  logic [1:0]    cnt;

  wire           accept  = (call_req | ret_req) & ~pend;
  wire           is_call = call_req;
  wire [PW-1:0]  sel     = use_b ? ptr_b : ptr_a;
  wire [PW-1:0]  sel_dn  = sel - 1'b1;
  wire [PW-1:0]  sel_up  = sel + 1'b1;
  wire [FW-1:0]  rd      = mem[sel_dn];
  wire [AW-1:0]  ret_adr = cur_pc + (delayed ? AW'(3) : AW'(1));
  wire [FW-1:0]  frame   = {cur_c, cur_z, {PADW{1'b0}}, ret_adr};
  wire [PW-1:0]  sel_nx  = is_call ? sel_up : sel_dn;

  wire [AW-1:0]  res_pc  = is_call ? target : rd[AW-1:0];
  wire           res_c   = (!is_call && rest_c) ? rd[FW-1] : cur_c;
  wire           res_z   = (!is_call && rest_z) ? rd[FW-2] : cur_z;

  always_ff @(posedge clk)
    if (accept && is_call) mem[sel] <= frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_a    <= '0;
      ptr_b    <= PW'(B_INIT);
      pend     <= 1'b0;
      cnt      <= '0;
      redirect <= 1'b0;
      new_pc   <= '0;
      new_c    <= 1'b0;
      new_z    <= 1'b0;
    end else begin
      redirect <= 1'b0;
      if (accept) begin
        if (use_b) ptr_b <= sel_nx;
        else       ptr_a <= sel_nx;
        new_pc <= res_pc;
        new_c  <= res_c;
        new_z  <= res_z;
        if (delayed) begin
          pend <= 1'b1;
          cnt  <= 2'd2;
        end else begin
          redirect <= 1'b1;
        end
      end else if (pend && issue) begin
        cnt <= cnt - 1'b1;
        if (cnt == 2'd1) begin
          pend     <= 1'b0;
          redirect <= 1'b1;
        end
      end
    end
  end

  a_r1_call_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !pend && !use_b) |=> ptr_a == $past(ptr_a) + 1'b1);

  a_r3_ret_ptr_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !pend && use_b) |=> ptr_b == $past(ptr_b) - 1'b1);

  a_r6_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((call_req || ret_req) && use_b) |=> $stable(ptr_a));

  a_r7_pending_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> ($stable(ptr_a) && $stable(ptr_b)));

  a_r5_strobe_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && $past(pend)) |-> $past(issue));

  a_r2_immediate_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((call_req || ret_req) && !pend && !delayed) |=> redirect);
endmodule

// File: tb/callret_stack_bench.sv
module callret_stack_bench;
  localparam int AW = 12, PW = 5, BI = 16, DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic call_req = 0, ret_req = 0, use_b = 0, delayed = 0, issue = 0;
  logic [AW-1:0] target = '0, cur_pc = '0;
  logic cur_c = 0, cur_z = 0, rest_c = 0, rest_z = 0;
  logic [AW-1:0] new_pc;
  logic new_c, new_z, redirect;
  logic [PW-1:0] ptr_a, ptr_b;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mm [DEPTH];
  int pa = 0, pb = BI, da = 0, db = 0;
  bit done = 0;

  always #10 clk = ~clk;

  callret_stack #(.AW(AW), .PW(PW), .B_INIT(BI)) u_callret_stack (
    .clk, .rst_n, .call_req, .ret_req, .use_b, .delayed, .issue, .target, .cur_pc,
    .cur_c, .cur_z, .rest_c, .rest_z, .new_pc, .new_c, .new_z, .redirect, .ptr_a, .ptr_b);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkframe(logic c, logic z, logic [AW-1:0] ra);
    return {c, z, {(30-AW){1'b0}}, ra};
  endfunction

  task automatic check_ptrs(string req);
    chk(req, 32'(ptr_a), 32'(pa));
    chk(req, 32'(ptr_b), 32'(pb));
  endtask

  // one call/return; call=1 -> call, else return. Returns after redirect checked.
  task automatic op(bit call, bit b, bit dly, logic [AW-1:0] tgt, logic [AW-1:0] pc,
                    bit c, bit z, bit rc, bit rz, bit stray);
    logic [AW-1:0] ep;
    logic ec, ez;
    logic [31:0] fr;
    int p;
    p = b ? pb : pa;
    if (call) begin
      mm[p[PW-1:0]] = mkframe(c, z, pc + (dly ? AW'(3) : AW'(1)));
      p = (p + 1) % DEPTH;
      ep = tgt; ec = c; ez = z;
    end else begin
      p = (p + DEPTH - 1) % DEPTH;
      fr = mm[p[PW-1:0]];
      ep = fr[AW-1:0];
      ec = rc ? fr[31] : c;
      ez = rz ? fr[30] : z;
    end
    if (b) pb = p; else pa = p;
    call_req = call; ret_req = !call; use_b = b; delayed = dly; target = tgt;
    cur_pc = pc; cur_c = c; cur_z = z; rest_c = rc; rest_z = rz;
    @(negedge clk);
    call_req = 0; ret_req = 0;
    check_ptrs(call ? "R1/R6" : "R3/R6");
    if (dly) begin
      chk("R5 no early redirect", 32'(redirect), 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      issue = 1; @(negedge clk); issue = 0;
      chk("R5 after one issue", 32'(redirect), 0);
      if (stray) begin
        call_req = $urandom_range(0, 1); ret_req = !call_req; use_b = $urandom_range(0, 1);
        delayed = 0;
        @(negedge clk);
        call_req = 0; ret_req = 0;
        check_ptrs("R7 ignored while pending");
        chk("R7 no redirect", 32'(redirect), 0);
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      issue = 1; @(negedge clk); issue = 0;
    end
    chk(dly ? "R5 redirect" : (call ? "R2 redirect" : "R3 redirect"), 32'(redirect), 1);
    chk(call ? "R2 new_pc" : "R3 new_pc", 32'(new_pc), 32'(ep));
    chk(call ? "R2 flags" : "R4 flags", {30'd0, new_c, new_z}, {30'd0, ec, ez});
    @(negedge clk);
    chk("R2 one-cycle strobe", 32'(redirect), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 redirect", 32'(redirect), 0);
    check_ptrs("R9 pointers");
    // R8 wrap: return with A empty
    ret_req = 1; use_b = 0; delayed = 0;
    @(negedge clk); ret_req = 0;
    pa = DEPTH - 1;
    chk("R8 wrap down", 32'(ptr_a), 32'(DEPTH - 1));
    @(negedge clk);
    op(1, 0, 0, 12'h123, 12'h0FF, 1, 0, 0, 0, 0);
    chk("R8 wrap up", 32'(ptr_a), 0);
    op(0, 0, 0, 0, 12'h500, 0, 1, 1, 1, 0);   // expect 0x100, C=1 Z=0
    chk("R2 return addr pc+1", 32'(new_pc), 32'h100);
    // R10 priority
    call_req = 1; ret_req = 1; use_b = 1; delayed = 0; target = 12'hABC;
    cur_pc = 12'h010; cur_c = 0; cur_z = 1;
    mm[pb[PW-1:0]] = mkframe(0, 1, 12'h011); pb = pb + 1;
    @(negedge clk); call_req = 0; ret_req = 0;
    chk("R10 call wins ptr", 32'(ptr_b), 32'(pb));
    chk("R10 call wins pc", 32'(new_pc), 32'hABC);
    @(negedge clk);
    // directed delayed call with stray request, then delayed return
    op(1, 0, 1, 12'h222, 12'h7FE, 1, 1, 0, 0, 1);
    op(0, 0, 1, 0, 12'h300, 0, 0, 1, 0, 1);
    chk("R5 return addr pc+3", 32'(new_pc), 32'h801);
    // random
    for (int i = 0; i < 200; i++) begin
      bit b, call;
      int d;
      b = $urandom_range(0, 1);
      d = b ? db : da;
      call = (d == 0) ? 1 : (d >= 8) ? 0 : $urandom_range(0, 1);
      op(call, b, ($urandom_range(0, 9) < 3), AW'($urandom), AW'($urandom),
         $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
         $urandom_range(0, 1), $urandom_range(0, 1));
      if (b) db = call ? db + 1 : db - 1;
      else   da = call ? da + 1 : da - 1;
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule